// File: doc/BRIEF.md
# DMA Request Line Router

This block sits between the peripherals' DMA request wires and a bank of DMA channels. It holds one routing entry per request line. Each entry carries an enable flag and a target channel number. When a routed line changes level, the block turns that change into a status event on the target channel.

Each channel remembers the last request level routed to it. A line that goes high while that stored level is low raises the channel's restart flag and pulses a run trigger toward the channel engine. A line that falls while the stored level is high raises the channel's end-of-receive flag. Software fills the routing entries through a small write port, which has two banks. The low bank addresses the first entries and the high bank addresses the ones past them. The channel status logic clears end-of-receive with a per-channel strobe.

Top module: `dreq_router`

## Requirements
- R1: After reset every routing entry is disabled, all restart, end-of-receive and trigger outputs are 0, and `map_err` is 0.
- R2: A write with `wr_bank`=0 updates entry `wr_off`. A write with `wr_bank`=1 updates entry LO_CNT+`wr_off` (64+`wr_off` by default). A high-bank write whose entry number would be NUM_REQ or more changes no entry.
- R3: A request line whose entry has the enable bit clear produces no flag and no trigger on any channel.
- R4: A write with `wr_vld`=1 and `wr_ch` >= NUM_CH sets `map_err`, which then stays 1 until reset. The entry is still stored, so the line no longer reaches its former channel. A write with `wr_vld`=0 never sets `map_err`.
- R5: A routed line that rises while the channel's stored level is 0 sets that channel's `ras_flag` bit at the next clock edge.
- R6: Any other routed event on a channel clears its `ras_flag`. That covers a fall, or a rise while the stored level is already 1.
- R7: A routed line that falls while the channel's stored level is 1 sets `eor_flag`. The flag holds until an `eor_clr` strobe for that channel arrives in a cycle with no new end-of-receive event. If both happen in the same cycle, the set wins.
- R8: After every event, the channel's stored level equals the new line value. A fall that follows a fall therefore sets no end-of-receive.
- R9: Every routed rising event pulses that channel's `run_trig` bit for exactly one cycle, whatever the stored level. A fall gives no pulse.
- R10: When several routed lines change on one channel in the same cycle, only the lowest-numbered line's change is taken as the event.
- R11: Each transition of a line gives exactly one event. A line held steady gives no further flags or trigger pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Routing entry write strobe |
| wr_bank | input | 1 | 0 = low bank, 1 = high bank |
| wr_off | input | OFF_W | Entry offset within the bank |
| wr_vld | input | 1 | Enable bit written to the entry |
| wr_ch | input | CHF_W | Channel number written to the entry |
| req_in | input | NUM_REQ | Peripheral request lines |
| eor_clr | input | NUM_CH | Per-channel end-of-receive clear strobes |
| ras_flag | output | NUM_CH | Per-channel restart (request after stop) flag |
| eor_flag | output | NUM_CH | Per-channel end-of-receive flag |
| run_trig | output | NUM_CH | One-cycle run pulse per channel |
| map_err | output | 1 | Sticky illegal channel number error |

## Verification
The bench sweeps every one of the 75 request lines through both write banks. Each line is routed to a channel computed from its index, then raised and dropped, so a misrouted line or a wrong bank offset shows up on the wrong channel bit. Separate patterns cover the following cases:
- two lines on one channel rising one after another, which tells restart apart from the cleared-by-repeat case;
- a simultaneous rise and fall on one channel, which reveals the priority order;
- a clear strobe that coincides with a new fall;
- disabled entries, out-of-range offsets and illegal channel numbers.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   typedef enum logic {
      BANK_LO = 1'b0,
      BANK_HI = 1'b1
   } bank_e;

   // entry number addressed by a bank/offset pair
   function automatic int unsigned entry_of(bank_e bank, int unsigned off, int unsigned lo_cnt);
      return (bank == BANK_HI) ? lo_cnt + off : off;
   endfunction
endpackage

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
   import dreq_pkg::*;
#(
   parameter int NUM_REQ = 75,
   parameter int LO_CNT  = 64,
   parameter int NUM_CH  = 16,
   parameter int CHF_W   = 5,
   parameter int OFF_W   = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic                            wr_bank,
   input  logic [OFF_W-1:0]                wr_off,
   input  logic                            wr_vld,
   input  logic [CHF_W-1:0]                wr_ch,
   output logic [NUM_REQ-1:0]              map_vld,
   output logic [NUM_REQ-1:0][CHF_W-1:0]   map_ch,
   output logic                            map_err
);
   localparam int IDX_W = $clog2(LO_CNT + (1 << OFF_W));

   logic [IDX_W-1:0] idx;
   logic             idx_ok;

   always_comb begin
      int unsigned e;
      e      = entry_of(bank_e'(wr_bank), int'(wr_off), LO_CNT);
      idx    = IDX_W'(e);
      idx_ok = (e < NUM_REQ) && ((wr_bank == 1'b1) || (int'(wr_off) < LO_CNT));
   end

   for (genvar e = 0; e < NUM_REQ; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map_vld[e] <= 1'b0;
            map_ch[e]  <= '0;
         end else if (wr_en && idx_ok && idx == IDX_W'(e)) begin
            map_vld[e] <= wr_vld;
            map_ch[e]  <= wr_ch;
         end
      end
   end

   // error detection only exists when the field can name a missing channel
   if ((1 << CHF_W) > NUM_CH) begin : g_err
      logic ch_bad;
      assign ch_bad = wr_ch >= CHF_W'(NUM_CH);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      map_err <= 1'b0;
         else if (wr_en && wr_vld && ch_bad) map_err <= 1'b1;
      end

      a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         $past(map_err) |-> map_err);
      a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(map_err) |-> $past(wr_en && wr_vld));
   end else begin : g_noerr
      assign map_err = 1'b0;
   end
endmodule

// File: rtl/dreq_edge.sv
module dreq_edge #(
   parameter int NUM_REQ = 75
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_in,
   output logic [NUM_REQ-1:0] edg
);
   logic [NUM_REQ-1:0] req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_in;
   end

   assign edg = req_in ^ req_q;
endmodule

// File: rtl/dreq_chan_evt.sv
module dreq_chan_evt #(
   parameter int NUM_REQ = 75,
   parameter int NUM_CH  = 16,
   parameter int CHF_W   = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_REQ-1:0]              req_in,
   input  logic [NUM_REQ-1:0]              edg,
   input  logic [NUM_REQ-1:0]              map_vld,
   input  logic [NUM_REQ-1:0][CHF_W-1:0]   map_ch,
   input  logic [NUM_CH-1:0]               eor_clr,
   output logic [NUM_CH-1:0]               ras_flag,
   output logic [NUM_CH-1:0]               eor_flag,
   output logic [NUM_CH-1:0]               run_trig
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      logic val;
      logic lvl;

      // descending scan: the lowest matching line is assigned last and wins
      always_comb begin
         hit = 1'b0;
         val = 1'b0;
         for (int l = NUM_REQ - 1; l >= 0; l--) begin
            if (edg[l] && map_vld[l] && map_ch[l] == CHF_W'(c)) begin
               hit = 1'b1;
               val = req_in[l];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl         <= 1'b0;
            ras_flag[c] <= 1'b0;
            eor_flag[c] <= 1'b0;
            run_trig[c] <= 1'b0;
         end else begin
            run_trig[c] <= hit && val;
            eor_flag[c] <= (eor_flag[c] && !eor_clr[c]) || (hit && lvl && !val);
            if (hit) begin
               lvl         <= val;
               ras_flag[c] <= !lvl && val;
            end
         end
      end

      a_r5_ras_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ras_flag[c]) |-> run_trig[c]);
      a_r6_eor_clears_ras: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(eor_flag[c]) |-> !ras_flag[c]);
      a_r7_eor_holds: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(eor_flag[c]) && !$past(eor_clr[c])) |-> eor_flag[c]);
      a_r8_ras_means_high: assert property (@(posedge clk) disable iff (!rst_n)
         ras_flag[c] |-> lvl);
      a_r9_no_trig_and_eor: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(eor_flag[c]) |-> !run_trig[c]);
   end
endmodule

// File: rtl/dreq_router.sv
module dreq_router #(
   parameter int NUM_REQ = 75,
   parameter int LO_CNT  = 64,
   parameter int NUM_CH  = 16,
   parameter int CHF_W   = 5,
   localparam int OFF_W  = $clog2(LO_CNT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_bank,
   input  logic [OFF_W-1:0]   wr_off,
   input  logic               wr_vld,
   input  logic [CHF_W-1:0]   wr_ch,
   input  logic [NUM_REQ-1:0] req_in,
   input  logic [NUM_CH-1:0]  eor_clr,
   output logic [NUM_CH-1:0]  ras_flag,
   output logic [NUM_CH-1:0]  eor_flag,
   output logic [NUM_CH-1:0]  run_trig,
   output logic               map_err
);
   if (NUM_REQ <= LO_CNT || NUM_REQ > 2 * LO_CNT) begin : g_bad_req
      $error("dreq_router: NUM_REQ must lie in (LO_CNT, 2*LO_CNT]");
   end
   if ((1 << CHF_W) < NUM_CH || NUM_CH < 1) begin : g_bad_ch
      $error("dreq_router: CHF_W too narrow for NUM_CH");
   end

   logic [NUM_REQ-1:0]            map_vld;
   logic [NUM_REQ-1:0][CHF_W-1:0] map_ch;
   logic [NUM_REQ-1:0]            edg;

   dreq_map_regs #(
      .NUM_REQ(NUM_REQ), .LO_CNT(LO_CNT), .NUM_CH(NUM_CH),
      .CHF_W(CHF_W), .OFF_W(OFF_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
      .wr_off(wr_off), .wr_vld(wr_vld), .wr_ch(wr_ch),
      .map_vld(map_vld), .map_ch(map_ch), .map_err(map_err)
   );

   dreq_edge #(.NUM_REQ(NUM_REQ)) u_edge (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .edg(edg)
   );

   dreq_chan_evt #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .CHF_W(CHF_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .edg(edg),
      .map_vld(map_vld), .map_ch(map_ch), .eor_clr(eor_clr),
      .ras_flag(ras_flag), .eor_flag(eor_flag), .run_trig(run_trig)
   );

   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (ras_flag == '0 && eor_flag == '0 && run_trig == '0));
endmodule

// File: tb/dreq_router_test.sv
module dreq_router_test;
   localparam int NREQ = 75;
   localparam int NCH  = 4;
   localparam int CW   = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic            wr_bank = 1'b0;
   logic [5:0]      wr_off = '0;
   logic            wr_vld = 1'b0;
   logic [CW-1:0]   wr_ch = '0;
   logic [NREQ-1:0] req_in = '0;
   logic [NCH-1:0]  eor_clr = '0;
   logic [NCH-1:0]  ras_flag, eor_flag, run_trig;
   logic            map_err;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dreq_router #(.NUM_REQ(NREQ), .LO_CNT(64), .NUM_CH(NCH), .CHF_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_off(wr_off),
      .wr_vld(wr_vld), .wr_ch(wr_ch), .req_in(req_in), .eor_clr(eor_clr),
      .ras_flag(ras_flag), .eor_flag(eor_flag), .run_trig(run_trig), .map_err(map_err)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wraw(bit bank, int off, bit v, int ch);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = bank; wr_off = 6'(off); wr_vld = v; wr_ch = CW'(ch);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wmap(int line, bit v, int ch);
      if (line < 64) wraw(1'b0, line, v, ch);
      else           wraw(1'b1, line - 64, v, ch);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: reset state
      chk("R1 ras", 32'(ras_flag), 0);
      chk("R1 eor", 32'(eor_flag), 0);
      chk("R1 trig", 32'(run_trig), 0);
      chk("R1 err", 32'(map_err), 0);
      // R1/R3: all lines unmapped after reset
      req_in = '1; step();
      chk("R1 unmapped ras", 32'(ras_flag), 0);
      chk("R3 unmapped trig", 32'(run_trig), 0);
      req_in = '0; step();
      chk("R3 unmapped eor", 32'(eor_flag), 0);

      // R2/R5/R7/R9/R11: sweep every line through both banks
      for (int l = 0; l < NREQ; l++) begin
         int ch;
         ch = l % NCH;
         wmap(l, 1'b1, ch);
         req_in[l] = 1'b1; step();
         chk("R5 ras set", 32'(ras_flag), 32'(1 << ch));
         chk("R9 trig pulse", 32'(run_trig), 32'(1 << ch));
         step();
         chk("R11 no repeat trig", 32'(run_trig), 0);
         chk("R11 ras kept", 32'(ras_flag), 32'(1 << ch));
         req_in[l] = 1'b0; step();
         chk("R7 eor set", 32'(eor_flag), 32'(1 << ch));
         chk("R6 ras cleared by fall", 32'(ras_flag), 0);
         chk("R9 no trig on fall", 32'(run_trig), 0);
         eor_clr = 4'(1 << ch); step(); eor_clr = '0;
         chk("R7 eor cleared", 32'(eor_flag), 0);
         wmap(l, 1'b0, 0);
      end

      // R2: high-bank offset past the last entry changes nothing
      wraw(1'b1, 11, 1'b1, 1);
      req_in = '1; step();
      chk("R2 out of range ras", 32'(ras_flag), 0);
      chk("R2 out of range trig", 32'(run_trig), 0);
      req_in = '0; step();

      // R3: entry with enable clear but a channel value
      wmap(7, 1'b0, 2);
      req_in[7] = 1'b1; step();
      chk("R3 disabled entry", 32'(run_trig), 0);
      req_in[7] = 1'b0; step();

      // R6/R8: two lines on channel 1
      wmap(10, 1'b1, 1); wmap(11, 1'b1, 1);
      req_in[10] = 1'b1; step();
      chk("R5 ch1 ras", 32'(ras_flag), 2);
      req_in[11] = 1'b1; step();
      chk("R6 rise while high clears ras", 32'(ras_flag), 0);
      chk("R9 trig on rise while high", 32'(run_trig), 2);
      req_in[10] = 1'b0; step();
      chk("R7 eor on fall", 32'(eor_flag), 2);
      eor_clr = 4'b0010; step(); eor_clr = '0;
      req_in[11] = 1'b0; step();
      chk("R8 second fall no eor", 32'(eor_flag), 0);
      wmap(10, 1'b0, 0); wmap(11, 1'b0, 0);

      // R10: lowest line wins on channel 3
      wmap(21, 1'b1, 3);
      req_in[21] = 1'b1; step();
      chk("R5 ch3 ras", 32'(ras_flag), 8);
      wmap(20, 1'b1, 3);
      req_in[20] = 1'b1; req_in[21] = 1'b0; step();
      chk("R10 trig from lower line", 32'(run_trig), 8);
      chk("R10 no eor from higher line", 32'(eor_flag), 0);
      chk("R10 ras cleared", 32'(ras_flag), 0);
      // R7: set wins over a simultaneous clear
      req_in[20] = 1'b0; eor_clr = 4'b1000; step(); eor_clr = '0;
      chk("R7 set beats clear", 32'(eor_flag), 8);
      step();
      chk("R7 eor held", 32'(eor_flag), 8);
      eor_clr = 4'b1000; step(); eor_clr = '0;
      chk("R7 eor clear", 32'(eor_flag), 0);
      wmap(20, 1'b0, 0); wmap(21, 1'b0, 0);

      // R4: illegal channel number
      wmap(3, 1'b0, 6);
      chk("R4 no err when disabled", 32'(map_err), 0);
      wmap(3, 1'b1, 2);
      wmap(3, 1'b1, 5);
      chk("R4 err set", 32'(map_err), 1);
      req_in[3] = 1'b1; step();
      chk("R4 entry overwritten", 32'(ras_flag), 0);
      chk("R4 entry overwritten trig", 32'(run_trig), 0);
      req_in[3] = 1'b0; step();
      wmap(3, 1'b1, 0);
      chk("R4 err sticky", 32'(map_err), 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule